// File: doc/BRIEF.md
# Camera Pixel Capture Synchronizer

This block sits on an 8-bit parallel camera port and runs on the camera's pixel clock. It works out where frames and lines begin and forwards only the active picture bytes. Each forwarded byte comes with a valid strobe. The first byte of each line also carries a line-start strobe, and the first byte of each frame carries a frame-start strobe. A static configuration input chooses between two ways of finding the picture.

In external-sync mode the block uses separate horizontal and vertical sync inputs. A static count of leading lines after each vertical sync is dropped. A static count of leading pixel clocks at the start of each horizontal sync window is also dropped.

In embedded-sync mode the sync pins are not used. The block watches the byte stream for four-byte timing codes made of FF, 00, 00 and a flag byte. The flag byte marks start or end of line and blanking or active lines. Only bytes between a start-of-active code and the next end code are forwarded. The code bytes themselves never appear at the output. Every byte goes through a fixed four-stage pipeline. This gives the block time to withdraw the three code bytes that were already captured when a code is recognised at its fourth byte.

Top module: `cam_sync_capture`

## Requirements
- R1: While rst_n is low and until the first byte has passed the pipeline, pix_valid, line_start and frame_start are all 0.
- R2: A byte sampled on din at clock edge n that is captured appears on pix_data with pix_valid = 1 in the cycle after edge n+3. All other cycles show pix_valid = 0.
- R3: External-sync mode (cfg_embedded = 0): the rising edges of hsync after a rising edge of vsync are numbered from 0. Lines whose number is below cfg_skip_lines produce no output. The line number saturates at the counter's all-ones value.
- R4: External-sync mode: within a kept line, the samples taken while hsync is 1 are numbered j from 0, starting at the sample where hsync rises. A sample is captured exactly when j >= cfg_skip_pix, with j saturating at all-ones. Samples taken while hsync is 0 are never captured.
- R5: External-sync mode: nothing is captured after reset until a rising edge of vsync has been seen.
- R6: Embedded-sync mode (cfg_embedded = 1): a code is the bytes FF, 00, 00, X with X[7] = 1. X[5] is the blanking flag V and X[4] is the end-of-line flag H. A code with H = 0 and V = 0 starts capture at the next byte. A code with H = 1 stops capture. None of the four code bytes is ever output.
- R7: Embedded-sync mode: bytes outside a start/end pair are discarded. So are bytes following a start code with V = 1. The hsync and vsync inputs have no effect.
- R8: Embedded-sync mode: a run that begins FF, 00 but fails to complete a code loses no captured byte. This covers FF, 00 followed by a nonzero byte, and FF, 00, 00 followed by a byte with bit 7 clear.
- R9: frame_start is 1 on the first captured byte after a vertical sync rise (external mode). In embedded mode it is 1 on the first captured byte after the first V = 0 start code that follows any code with V = 1. It is 1 once per frame.
- R10: line_start is 1 on the first captured byte of each line. line_start and frame_start are only 1 together with pix_valid, and frame_start implies line_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_embedded | input | 1 | 1 selects embedded-code mode, 0 selects sync-pin mode |
| cfg_skip_lines | input | LINE_W | Lines dropped after vertical sync |
| cfg_skip_pix | input | PIX_W | Pixel clocks dropped at the start of each hsync window |
| hsync | input | 1 | Horizontal sync, active high |
| vsync | input | 1 | Vertical sync, active high |
| din | input | 8 | Camera data byte |
| pix_data | output | 8 | Captured byte |
| pix_valid | output | 1 | pix_data holds a captured byte |
| line_start | output | 1 | First captured byte of a line |
| frame_start | output | 1 | First captured byte of a frame |

## Verification
The bench builds the block with LINE_W = 4 and PIX_W = 4. With these widths, all sixteen combinations of line skip 0..3 and pixel skip 0..3 can be swept in turn, and both saturating counters reach their limit of 15 within a 20-pixel line and an 18-line frame. Embedded frames vary the number of blank lines, active lines and pixels per line. One active line carries false FF, 00 runs, and hsync and vsync toggle throughout. Each frame's pixel, line-start and frame-start totals are compared with the geometry computed in the bench.

// File: rtl/cam_sync_pkg.sv
package cam_sync_pkg;
  localparam int BYTE_W   = 8;
  localparam int CODE_LEN = 4;
  localparam logic [BYTE_W-1:0] CODE_LEAD = 8'hFF;
  localparam logic [BYTE_W-1:0] CODE_ZERO = 8'h00;

  // One byte travelling through the capture pipeline.
  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              valid;
    logic              lfirst;
    logic              ffirst;
  } pix_tag_t;
endpackage

// File: rtl/cam_ext_gate.sv
module cam_ext_gate #(
  parameter int LINE_W = 12,
  parameter int PIX_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              vsync,
  input  logic [LINE_W-1:0] skip_lines,
  input  logic [PIX_W-1:0]  skip_pix,
  output logic              cap_o,
  output logic              lfirst_o,
  output logic              ffirst_o
);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;
  localparam logic [PIX_W-1:0]  PIX_MAX  = '1;

  logic              hs_q, vs_q, seen_q, line_ok_q, lpend_q, fpend_q;
  logic [LINE_W-1:0] line_q;
  logic [PIX_W-1:0]  pix_q;

  logic              seen_n, line_ok_n, lpend_n, fpend_n;
  logic [LINE_W-1:0] line_n, line_base;
  logic [PIX_W-1:0]  pix_n, pix_idx;
  logic              hs_rise, vs_rise;

  always_comb begin
    hs_rise   = hsync & ~hs_q;
    vs_rise   = vsync & ~vs_q;
    line_base = vs_rise ? '0 : line_q;
    pix_idx   = hs_rise ? '0 : pix_q;
    line_ok_n = hs_rise ? (line_base >= skip_lines) : line_ok_q;
    seen_n    = seen_q | vs_rise;
    cap_o     = seen_n & hsync & line_ok_n & (pix_idx >= skip_pix);
    lfirst_o  = hs_rise | lpend_q;
    ffirst_o  = vs_rise | fpend_q;
    line_n    = line_base;
    if (hs_rise && (line_base != LINE_MAX)) line_n = line_base + LINE_W'(1);
    pix_n = pix_q;
    if (hsync) pix_n = (pix_idx == PIX_MAX) ? PIX_MAX : pix_idx + PIX_W'(1);
    lpend_n = cap_o ? 1'b0 : lfirst_o;
    fpend_n = cap_o ? 1'b0 : ffirst_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q      <= 1'b0;
      vs_q      <= 1'b0;
      seen_q    <= 1'b0;
      line_ok_q <= 1'b0;
      lpend_q   <= 1'b0;
      fpend_q   <= 1'b0;
      line_q    <= LINE_MAX;
      pix_q     <= PIX_MAX;
    end else begin
      hs_q      <= hsync;
      vs_q      <= vsync;
      seen_q    <= seen_n;
      line_ok_q <= line_ok_n;
      lpend_q   <= lpend_n;
      fpend_q   <= fpend_n;
      line_q    <= line_n;
      pix_q     <= pix_n;
    end
  end

  // R4: no capture outside the hsync window
  a_r4_needs_hsync: assert property (@(posedge clk) disable iff (!rst_n)
    cap_o |-> hsync);
  // R5: capture needs a vertical sync seen now or earlier
  a_r5_needs_vsync: assert property (@(posedge clk) disable iff (!rst_n)
    cap_o |-> (seen_q || vsync));
endmodule

// File: rtl/cam_emb_gate.sv
module cam_emb_gate
  import cam_sync_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] din,
  output logic              cap_o,
  output logic              lfirst_o,
  output logic              ffirst_o,
  output logic              kill_o
);
  logic [BYTE_W-1:0] h0_q, h1_q, h2_q;
  logic              act_q, lpend_q, fpend_q, fgo_q;
  logic              act_n, lpend_n, fpend_n, fgo_n;
  logic              match, end_flag, blank_flag;

  always_comb begin
    match      = (h2_q == CODE_LEAD) && (h1_q == CODE_ZERO) &&
                 (h0_q == CODE_ZERO) && din[7];
    end_flag   = din[4];
    blank_flag = din[5];
    cap_o      = act_q & ~match;
    kill_o     = match;
    lfirst_o   = lpend_q;
    ffirst_o   = fgo_q;
    act_n      = act_q;
    lpend_n    = lpend_q;
    fpend_n    = fpend_q;
    fgo_n      = fgo_q;
    if (match) begin
      if (blank_flag) fpend_n = 1'b1;
      if (end_flag) begin
        act_n = 1'b0;
      end else begin
        act_n   = ~blank_flag;
        lpend_n = ~blank_flag;
        if (!blank_flag && fpend_q) begin
          fgo_n   = 1'b1;
          fpend_n = 1'b0;
        end
      end
    end else if (cap_o) begin
      lpend_n = 1'b0;
      fgo_n   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h0_q    <= '0;
      h1_q    <= '0;
      h2_q    <= '0;
      act_q   <= 1'b0;
      lpend_q <= 1'b0;
      fpend_q <= 1'b0;
      fgo_q   <= 1'b0;
    end else begin
      h0_q    <= din;
      h1_q    <= h0_q;
      h2_q    <= h1_q;
      act_q   <= act_n;
      lpend_q <= lpend_n;
      fpend_q <= fpend_n;
      fgo_q   <= fgo_n;
    end
  end

  // R6: the flag byte of a code is never captured
  a_r6_code_not_captured: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> !cap_o);
  // R6: an end code stops capture on the following byte
  a_r6_end_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (match && din[4]) |=> !cap_o);
endmodule

// File: rtl/cam_kill_pipe.sv
module cam_kill_pipe
  import cam_sync_pkg::*;
#(
  parameter int DEPTH = CODE_LEN
) (
  input  logic     clk,
  input  logic     rst_n,
  input  pix_tag_t in_tag,
  input  logic     kill,
  output pix_tag_t out_tag
);
  pix_tag_t st [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    pix_tag_t nxt;
    if (g == 0) begin : g_head
      always_comb nxt = in_tag;
    end else begin : g_body
      always_comb begin
        nxt = st[g-1];
        if (kill) nxt.valid = 1'b0;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[g] <= '0;
      else        st[g] <= nxt;
    end
  end

  assign out_tag = st[DEPTH-1];
endmodule

// File: rtl/cam_sync_capture.sv
module cam_sync_capture
  import cam_sync_pkg::*;
#(
  parameter int LINE_W = 12,
  parameter int PIX_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_embedded,
  input  logic [LINE_W-1:0] cfg_skip_lines,
  input  logic [PIX_W-1:0]  cfg_skip_pix,
  input  logic              hsync,
  input  logic              vsync,
  input  logic [7:0]        din,
  output logic [7:0]        pix_data,
  output logic              pix_valid,
  output logic              line_start,
  output logic              frame_start
);
  logic     x_cap, x_lf, x_ff;
  logic     e_cap, e_lf, e_ff, e_kill;
  pix_tag_t head, tail;
  logic     kill;

  cam_ext_gate #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_ext (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .skip_lines(cfg_skip_lines), .skip_pix(cfg_skip_pix),
    .cap_o(x_cap), .lfirst_o(x_lf), .ffirst_o(x_ff));

  cam_emb_gate u_emb (
    .clk(clk), .rst_n(rst_n), .din(din),
    .cap_o(e_cap), .lfirst_o(e_lf), .ffirst_o(e_ff), .kill_o(e_kill));

  always_comb begin
    head.data   = din;
    head.valid  = cfg_embedded ? e_cap : x_cap;
    head.lfirst = cfg_embedded ? e_lf  : x_lf;
    head.ffirst = cfg_embedded ? e_ff  : x_ff;
    kill        = cfg_embedded & e_kill;
  end

  cam_kill_pipe #(.DEPTH(CODE_LEN)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_tag(head), .kill(kill), .out_tag(tail));

  always_comb begin
    pix_data    = tail.data;
    pix_valid   = tail.valid;
    line_start  = tail.valid & tail.lfirst;
    frame_start = tail.valid & tail.ffirst;
  end

  // R10: strobes only ride on valid bytes
  a_r10_strobe_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start || frame_start) |-> pix_valid);
  // R10: a frame start is always a line start
  a_r10_frame_is_line: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> line_start);
endmodule

// File: tb/tb_cam_sync_capture.sv
module tb_cam_sync_capture;
  localparam int LW = 4;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_embedded = 1'b0;
  logic [LW-1:0] cfg_skip_lines = '0;
  logic [PW-1:0] cfg_skip_pix = '0;
  logic          hsync = 1'b0, vsync = 1'b0;
  logic [7:0]    din = 8'h10;
  logic [7:0]    pix_data;
  logic          pix_valid, line_start, frame_start;

  always #2.5 clk = ~clk;  // 200 MHz

  cam_sync_capture #(.LINE_W(LW), .PIX_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_embedded(cfg_embedded),
    .cfg_skip_lines(cfg_skip_lines), .cfg_skip_pix(cfg_skip_pix),
    .hsync(hsync), .vsync(vsync), .din(din),
    .pix_data(pix_data), .pix_valid(pix_valid),
    .line_start(line_start), .frame_start(frame_start));

  int checks = 0, errors = 0;
  bit done = 0;

  // expectation ring: entry written now is checked four steps later (R2)
  logic [7:0] r_d [8];
  logic       r_v [8], r_ls [8], r_fs [8];
  string      r_tag [8];
  int         wp = 0;
  int         obs_v, obs_ls, obs_fs, exp_v, exp_ls, exp_fs;
  bit         lpend, fpend, fgo;
  int         tick = 0;

  task automatic fail(input string tag, input string what, input int act, input int exp);
    errors++;
    $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
  endtask

  task automatic chk_out();
    int i;
    i = (wp + 4) % 8;
    checks++;
    if (pix_valid !== r_v[i]) fail(r_tag[i], "pix_valid", pix_valid, r_v[i]);
    else if (r_v[i] && pix_data !== r_d[i]) fail("R2", "pix_data", pix_data, r_d[i]);
    else if (line_start !== r_ls[i]) fail("R10", "line_start", line_start, r_ls[i]);
    else if (frame_start !== r_fs[i]) fail("R9", "frame_start", frame_start, r_fs[i]);
    if (pix_valid) obs_v++;
    if (line_start) obs_ls++;
    if (frame_start) obs_fs++;
  endtask

  task automatic step(input logic [7:0] d, input logic hs, input logic vs,
                      input logic ev, input logic els, input logic efs, input string tag);
    @(negedge clk);
    chk_out();
    din = d; hsync = hs; vsync = vs;
    r_d[wp] = d; r_v[wp] = ev; r_ls[wp] = els; r_fs[wp] = efs; r_tag[wp] = tag;
    wp = (wp + 1) % 8;
    tick++;
    if (ev) exp_v++;
    if (els) exp_ls++;
    if (efs) exp_fs++;
  endtask

  task automatic begin_frame();
    obs_v = 0; obs_ls = 0; obs_fs = 0; exp_v = 0; exp_ls = 0; exp_fs = 0;
  endtask

  task automatic end_frame(input string tag);
    for (int k = 0; k < 5; k++) step(8'h10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    checks++;
    if (obs_v != exp_v) fail(tag, "pixels per frame", obs_v, exp_v);
    checks++;
    if (obs_ls != exp_ls) fail(tag, "lines per frame", obs_ls, exp_ls);
    checks++;
    if (obs_fs != exp_fs) fail("R9", "frames", obs_fs, exp_fs);
  endtask

  // External-sync frame: skip decisions from R3/R4, strobes from R9/R10
  task automatic ext_frame(input int nl, input int hl, input int gap);
    int skl, skp;
    bit ev;
    skl = int'(cfg_skip_lines);
    skp = int'(cfg_skip_pix);
    begin_frame();
    step(8'h11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
    step(8'h11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
    fpend = 1;
    step(8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
    for (int l = 0; l < nl; l++) begin
      lpend = 1;
      for (int j = 0; j < hl; j++) begin
        ev = (l >= skl) && (j >= skp);
        step(8'(8'h20 + l * 4 + j), 1'b1, 1'b0, ev, ev && lpend, ev && fpend,
             (l < skl) ? "R3" : "R4");
        if (ev) begin lpend = 0; fpend = 0; end
      end
      for (int g = 0; g < gap; g++) step(8'h12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
    end
    end_frame("R3");
  endtask

  // Embedded code bytes: never output (R6); frame tracking as in R9
  task automatic code(input bit v, input bit h);
    logic [7:0] xy;
    xy = v ? (h ? 8'hB6 : 8'hAB) : (h ? 8'h9D : 8'h80);
    step(8'hFF, tick[0], tick[1], 1'b0, 1'b0, 1'b0, "R6");
    step(8'h00, tick[0], tick[1], 1'b0, 1'b0, 1'b0, "R6");
    step(8'h00, tick[0], tick[1], 1'b0, 1'b0, 1'b0, "R6");
    step(xy,    tick[0], tick[1], 1'b0, 1'b0, 1'b0, "R6");
    if (v) fpend = 1;
    if (!h && !v) begin
      lpend = 1;
      if (fpend) begin fgo = 1; fpend = 0; end
    end
  endtask

  task automatic emb_line(input bit v, input int npix, input bit salt);
    logic [7:0] d;
    code(v, 1'b1);
    for (int k = 0; k < 4; k++)
      step(k[0] ? 8'h10 : 8'h80, tick[0], tick[2], 1'b0, 1'b0, 1'b0, "R7");
    code(v, 1'b0);
    for (int p = 0; p < npix; p++) begin
      d = 8'(8'h20 + (p * 7) % 200);
      if (salt) begin
        // R8: broken prefixes FF,00,33 and FF,00,00,12 stay pixels
        case (p)
          2: d = 8'hFF; 3: d = 8'h00; 4: d = 8'h33;
          6: d = 8'hFF; 7: d = 8'h00; 8: d = 8'h00; 9: d = 8'h12;
          default: ;
        endcase
      end
      if (v) step(p[0] ? 8'h10 : 8'h80, tick[0], tick[1], 1'b0, 1'b0, 1'b0, "R7");
      else begin
        step(d, tick[0], tick[1], 1'b1, lpend, fgo, salt ? "R8" : "R6");
        lpend = 0; fgo = 0;
      end
    end
  endtask

  task automatic emb_frame(input int nb, input int na, input int npix, input int salt_line);
    begin_frame();
    for (int b = 0; b < nb; b++) emb_line(1'b1, npix, 1'b0);
    for (int a = 0; a < na; a++) emb_line(1'b0, (a == salt_line) ? 12 : npix, a == salt_line);
    code(1'b1, 1'b1);
    end_frame("R7");
  endtask

  initial begin
    for (int k = 0; k < 8; k++) begin
      r_v[k] = 0; r_ls[k] = 0; r_fs[k] = 0; r_d[k] = 0; r_tag[k] = "R1";
    end
    repeat (3) @(negedge clk);
    checks++;  // R1: outputs idle in reset
    if (pix_valid || line_start || frame_start)
      fail("R1", "outputs in reset", {pix_valid, line_start, frame_start}, 0);
    rst_n = 1'b1;
    begin_frame();
    // R5: hsync windows before any vsync capture nothing
    for (int l = 0; l < 3; l++) begin
      for (int j = 0; j < 5; j++) step(8'h30, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
      step(8'h31, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    end
    end_frame("R5");
    // R3/R4 sweep over skip settings
    for (int sl = 0; sl < 4; sl++)
      for (int sp = 0; sp < 4; sp++) begin
        cfg_skip_lines = LW'(sl);
        cfg_skip_pix   = PW'(sp);
        ext_frame(5, 6, 3);
      end
    // R4: pixel counter saturation
    cfg_skip_lines = 0; cfg_skip_pix = 15;
    ext_frame(2, 20, 2);
    // R3: line counter saturation
    cfg_skip_lines = 15; cfg_skip_pix = 1;
    ext_frame(18, 4, 2);
    // embedded mode, hsync/vsync toggling (R7)
    cfg_embedded = 1'b1;
    fpend = 0; fgo = 0; lpend = 0;
    emb_frame(2, 3, 8, -1);
    emb_frame(1, 2, 12, 1);
    for (int na = 1; na <= 3; na++)
      for (int np = 1; np <= 6; np++) emb_frame(1, na, np, -1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule